// File: doc/BRIEF.md
# Dual Timer/Counter Pair

Two byte-addressed timer/counters for a microcontroller core. Each timer counts either CPU clock periods through its own prescaler (one step every 4 or every 12 clocks, chosen per timer) or falling edges on an external pin. Counting can be gated by an external level input. Each timer has four count modes: a 13-bit counter, a 16-bit counter, an 8-bit counter with automatic reload, and a split mode.

When timer 0 is in split mode, its low byte and high byte become two separate 8-bit counters. The high byte counts clocks only. It borrows timer 1's run bit and timer 1's overflow flag. In that situation timer 1 is started and stopped through its own mode field alone. Its overflows still appear on the baud tick output, which feeds a serial port's bit-rate logic.

Software uses a single-cycle write port and a combinational read port. A select code picks the register. The two sticky overflow flags are exported for the interrupt logic.

Top module: `tmr_pair`

## Requirements
- R1: After reset every count byte, the mode byte, the control byte and the rate byte read 0, and ovf0_flag, ovf1_flag and baud_tick are low. Select codes: 0 timer-0 low, 1 timer-0 high, 2 timer-1 low, 3 timer-1 high, 4 mode, 5 control, 6 rate.
- R2: In clock mode a running timer steps once every 4 clocks when its rate bit is 1 and once every 12 clocks when it is 0. The rate bit is bit 3 of the rate byte for timer 0 and bit 4 for timer 1, and the two bits are independent. A timer's prescaler restarts from zero whenever counting is enabled or its rate bit changes, so the first step comes 4 or 12 clocks after the enabling write.
- R3: Mode 1 (mode field 1) counts the high:low pair as one 16-bit value. Stepping from 0xFFFF wraps it to 0x0000 and sets the timer's flag.
- R4: Mode 0 (mode field 0) counts high byte : low bits 4..0 as a 13-bit value and leaves low bits 7..5 unchanged. Stepping from all ones wraps it to zero and sets the flag.
- R5: Mode 2 (mode field 2) counts the low byte. When the low byte steps from 0xFF, it is reloaded from the high byte and the flag is set.
- R6: With the pin-source bit set (mode-byte bit 2 for timer 0, bit 6 for timer 1), a running timer steps exactly once for each high-to-low transition of its pin and never on clock periods.
- R7: With the gate bit set (mode-byte bit 3 for timer 0, bit 7 for timer 1), a timer steps only while its run bit is 1 and its gate input is high.
- R8: Control byte bits are run0 (bit 0), run1 (bit 1), flag0 (bit 2) and flag1 (bit 3). Once set, a flag stays set until a control write loads a 0 into it.
- R9: A write to a count byte in the same cycle as a step of that byte stores the written value, and the step is lost.
- R10: With timer 0 in split mode (mode field 3), the timer-0 low byte counts under run0, the gate and the pin source, and sets flag0. The timer-0 high byte counts clock periods at timer 0's rate while run1 is 1, and sets flag1 when it wraps.
- R11: While timer 0 is not in split mode, timer 1 in mode 3 holds its count even with run1 set.
- R12: While timer 0 is in split mode, timer 1 counts whenever its own mode field is 0, 1 or 2 (subject to its gate), ignores run1, stops in mode 3, and never sets flag1.
- R13: baud_tick is a one-cycle pulse, one for each timer-1 overflow, in every configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 8 | Read data (combinational) |
| t0_pin | input | 1 | External count pin, timer 0 |
| t1_pin | input | 1 | External count pin, timer 1 |
| gate0_in | input | 1 | Gate level input, timer 0 |
| gate1_in | input | 1 | Gate level input, timer 1 |
| ovf0_flag | output | 1 | Sticky overflow flag 0 |
| ovf1_flag | output | 1 | Sticky overflow flag 1 |
| baud_tick | output | 1 | One-cycle pulse per timer-1 overflow |

## Verification
The counting path is driven with start values just below each mode's wrap point: 0xFFFE in 16-bit mode, all-ones in 13-bit mode and 0xFE under reload. These show whether carries cross the right bit boundary and whether a flag or a reload follows. Run windows are sized in exact multiples of 4 and 12 clocks, and both timers are configured at opposite rates, so an off-by-one prescaler or a rate bit that reaches the wrong timer gives a different count. Pin pulses, gate-low windows, a write landing on a step edge and the split-mode borrowing of run1 and flag1 are each run separately, so that a wrong owner of a control bit shows up as a count in the wrong byte.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;

   typedef enum logic [1:0] {
      MD_13     = 2'd0,
      MD_16     = 2'd1,
      MD_RELOAD = 2'd2,
      MD_SPLIT  = 2'd3
   } tmode_e;

   typedef struct packed {
      logic   gate;
      logic   pin_src;
      tmode_e mode;
   } tcfg_t;

   localparam logic [2:0] SEL_T0L  = 3'd0;
   localparam logic [2:0] SEL_T0H  = 3'd1;
   localparam logic [2:0] SEL_T1L  = 3'd2;
   localparam logic [2:0] SEL_T1H  = 3'd3;
   localparam logic [2:0] SEL_MODE = 3'd4;
   localparam logic [2:0] SEL_CTRL = 3'd5;
   localparam logic [2:0] SEL_RATE = 3'd6;

endpackage

// File: rtl/tmr_pair_prescale.sv
module tmr_pair_prescale #(
   parameter int SLOW_DIV = 12,
   parameter int FAST_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic fast,
   output logic tick
);
   localparam int CW = $clog2(SLOW_DIV);
   localparam logic [CW-1:0] SLIM = CW'(SLOW_DIV - 1);
   localparam logic [CW-1:0] FLIM = CW'(FAST_DIV - 1);

   initial begin : p_param_chk
      assert (FAST_DIV >= 2 && SLOW_DIV > FAST_DIV)
         else $fatal(1, "prescale divisors out of range");
   end

   logic [CW-1:0] pc;
   logic          fast_q;
   logic          changed;
   logic [CW-1:0] lim;

   always_comb begin
      changed = (fast != fast_q);
      lim     = fast ? FLIM : SLIM;
      tick    = en && !changed && (pc == lim);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc     <= '0;
         fast_q <= 1'b0;
      end else begin
         fast_q <= fast;
         if (!en || changed || tick) pc <= '0;
         else                        pc <= pc + 1'b1;
      end
   end

   // R2: steps are never back to back
   a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/tmr_pair_edge.sv
module tmr_pair_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic fall
);
   initial begin : p_param_chk
      assert (STAGES >= 1) else $fatal(1, "STAGES must be at least 1");
   end

   logic [STAGES:0] sh;

   always_ff @(posedge clk) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-1:0], pin};
   end

   assign fall = sh[STAGES] & ~sh[STAGES-1];

   // R6: one edge gives one single-cycle event
   a_r6_one_event: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);

endmodule

// File: rtl/tmr_pair_unit.sv
module tmr_pair_unit
   import tmr_pair_pkg::*;
#(
   parameter bit SPLIT = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  tmode_e     mode,
   input  logic       inc,
   input  logic       inc_hi,
   input  logic       wr_lo,
   input  logic       wr_hi,
   input  logic [7:0] wdata,
   output logic [7:0] lo,
   output logic [7:0] hi,
   output logic       ovf,
   output logic       ovf_hi
);
   logic [7:0]  nlo, nhi;
   logic [12:0] c13;
   logic [15:0] c16;

   always_comb begin
      nlo    = lo;
      nhi    = hi;
      ovf    = 1'b0;
      ovf_hi = 1'b0;
      c13    = {hi, lo[4:0]} + 13'd1;
      c16    = {hi, lo} + 16'd1;
      unique case (mode)
         MD_13: if (inc) begin
            nlo = {lo[7:5], c13[4:0]};
            nhi = c13[12:5];
            ovf = &{hi, lo[4:0]};
         end
         MD_16: if (inc) begin
            {nhi, nlo} = c16;
            ovf = &{hi, lo};
         end
         MD_RELOAD: if (inc) begin
            ovf = &lo;
            nlo = (&lo) ? hi : lo + 8'd1;
         end
         MD_SPLIT: if (SPLIT) begin
            if (inc) begin
               nlo = lo + 8'd1;
               ovf = &lo;
            end
            if (inc_hi) begin
               nhi    = hi + 8'd1;
               ovf_hi = &hi;
            end
         end
         default: ;
      endcase
      if (wr_lo) nlo = wdata;
      if (wr_hi) nhi = wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo <= '0;
         hi <= '0;
      end else begin
         lo <= nlo;
         hi <= nhi;
      end
   end

   // R9: a software write lands regardless of a step
   a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (lo == $past(wdata)));

   // R5: wrap of the low byte reloads from the high byte
   a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_RELOAD && inc && lo == 8'hFF && !wr_lo) |=> (lo == $past(hi)));

   // R11: without the split variant, mode 3 freezes the count
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!SPLIT && mode == MD_SPLIT && !wr_lo && !wr_hi) |=> $stable({hi, lo}));

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
   import tmr_pair_pkg::*;
#(
   parameter int SLOW_DIV    = 12,
   parameter int FAST_DIV    = 4,
   parameter int SYNC_STAGES = 2,
   parameter int T0_RATE_BIT = 3,
   parameter int T1_RATE_BIT = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [2:0] wr_sel,
   input  logic [7:0] wr_data,
   input  logic [2:0] rd_sel,
   output logic [7:0] rd_data,
   input  logic       t0_pin,
   input  logic       t1_pin,
   input  logic       gate0_in,
   input  logic       gate1_in,
   output logic       ovf0_flag,
   output logic       ovf1_flag,
   output logic       baud_tick
);
   localparam int NT = 2;
   localparam int NP = NT + 1;   // one prescaler per timer plus the split high byte

   initial begin : p_param_chk
      assert (T0_RATE_BIT != T1_RATE_BIT && T0_RATE_BIT < 8 && T1_RATE_BIT < 8)
         else $fatal(1, "rate bit positions invalid");
   end

   tcfg_t      cfg   [NT];
   logic       run   [NT];
   logic       fast  [NT];
   logic       pin   [NT];
   logic       gin   [NT];
   logic       fall  [NT];
   logic       act   [NT];
   logic       inc   [NT];
   logic       inc_h [NT];
   logic       wr_l  [NT];
   logic       wr_h  [NT];
   logic [7:0] lo    [NT];
   logic [7:0] hi    [NT];
   logic       ovf   [NT];
   logic       ovf_h [NT];
   logic       p_en  [NP];
   logic       p_fast[NP];
   logic       p_tick[NP];

   logic split, ctrl_wr, act0h;

   always_comb begin
      pin[0]  = t0_pin;
      pin[1]  = t1_pin;
      gin[0]  = gate0_in;
      gin[1]  = gate1_in;
      split   = (cfg[0].mode == MD_SPLIT);
      ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
      act[0]  = run[0] && (!cfg[0].gate || gin[0]);
      act[1]  = (split ? (cfg[1].mode != MD_SPLIT) : run[1]) && (!cfg[1].gate || gin[1]);
      act0h   = split && run[1];
      for (int i = 0; i < NT; i++) begin
         p_en[i]   = act[i] && !cfg[i].pin_src;
         p_fast[i] = fast[i];
         inc[i]    = act[i] && (cfg[i].pin_src ? fall[i] : p_tick[i]);
         wr_l[i]   = wr_en && (wr_sel == 3'(2 * i));
         wr_h[i]   = wr_en && (wr_sel == 3'(2 * i + 1));
      end
      p_en[NT]   = act0h;
      p_fast[NT] = fast[0];
      inc_h[0]   = p_tick[NT];
      inc_h[1]   = 1'b0;
   end

   for (genvar p = 0; p < NP; p++) begin : g_pre
      tmr_pair_prescale #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_pre (
         .clk(clk), .rst_n(rst_n), .en(p_en[p]), .fast(p_fast[p]), .tick(p_tick[p]));
   end

   for (genvar t = 0; t < NT; t++) begin : g_tmr
      tmr_pair_edge #(.STAGES(SYNC_STAGES)) u_edge (
         .clk(clk), .rst_n(rst_n), .pin(pin[t]), .fall(fall[t]));
      tmr_pair_unit #(.SPLIT(t == 0)) u_unit (
         .clk(clk), .rst_n(rst_n), .mode(cfg[t].mode), .inc(inc[t]), .inc_hi(inc_h[t]),
         .wr_lo(wr_l[t]), .wr_hi(wr_h[t]), .wdata(wr_data),
         .lo(lo[t]), .hi(hi[t]), .ovf(ovf[t]), .ovf_hi(ovf_h[t]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg[0]    <= '0;
         cfg[1]    <= '0;
         run[0]    <= 1'b0;
         run[1]    <= 1'b0;
         fast[0]   <= 1'b0;
         fast[1]   <= 1'b0;
         ovf0_flag <= 1'b0;
         ovf1_flag <= 1'b0;
         baud_tick <= 1'b0;
      end else begin
         if (wr_en && wr_sel == SEL_MODE) begin
            cfg[0] <= tcfg_t'(wr_data[3:0]);
            cfg[1] <= tcfg_t'(wr_data[7:4]);
         end
         if (wr_en && wr_sel == SEL_RATE) begin
            fast[0] <= wr_data[T0_RATE_BIT];
            fast[1] <= wr_data[T1_RATE_BIT];
         end
         if (ctrl_wr) begin
            run[0] <= wr_data[0];
            run[1] <= wr_data[1];
         end
         ovf0_flag <= (ctrl_wr ? wr_data[2] : ovf0_flag) | ovf[0];
         ovf1_flag <= (ctrl_wr ? wr_data[3] : ovf1_flag)
                      | (split ? (ovf_h[0] | ovf_h[1]) : ovf[1]);
         baud_tick <= ovf[1];
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_sel)
         SEL_T0L:  rd_data = lo[0];
         SEL_T0H:  rd_data = hi[0];
         SEL_T1L:  rd_data = lo[1];
         SEL_T1H:  rd_data = hi[1];
         SEL_MODE: rd_data = {cfg[1], cfg[0]};
         SEL_CTRL: rd_data = {4'b0, ovf1_flag, ovf0_flag, run[1], run[0]};
         SEL_RATE: begin
            rd_data[T0_RATE_BIT] = fast[0];
            rd_data[T1_RATE_BIT] = fast[1];
         end
         default:  rd_data = '0;
      endcase
   end

   // R8: a flag only drops through a control write
   a_r8_flag0_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf0_flag && !ctrl_wr) |=> ovf0_flag);
   a_r8_flag1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf1_flag && !ctrl_wr) |=> ovf1_flag);

   // R13: the baud tick is a single-cycle pulse
   a_r13_baud_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      baud_tick |=> !baud_tick);

   // R12: in split mode timer 1 never raises flag1
   a_r12_no_t1_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (split && !ovf1_flag && !ctrl_wr && !inc_h[0]) |=> !ovf1_flag);

endmodule

// File: tb/tb_tmr_pair.sv
module tb_tmr_pair;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_sel = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_sel = '0;
   logic [7:0] rd_data;
   logic       t0_pin = 1'b1;
   logic       t1_pin = 1'b1;
   logic       gate0_in = 1'b0;
   logic       gate1_in = 1'b0;
   logic       ovf0_flag, ovf1_flag, baud_tick;

   int total = 0;
   int bad = 0;
   int baud_cnt = 0;

   // mode, rate, tsel, start lo, start hi, run+1, exp lo, exp hi, exp flag
   localparam logic [71:0] VEC [7] = '{
      {8'h01, 8'h08, 8'h00, 8'hFE, 8'hFF, 8'd16, 8'h02, 8'h00, 8'h01},  // R3 fast wrap
      {8'h01, 8'h00, 8'h00, 8'hFF, 8'h00, 8'd36, 8'h02, 8'h01, 8'h00},  // R2 R3 slow carry
      {8'h00, 8'h08, 8'h00, 8'hFE, 8'h00, 8'd16, 8'hE2, 8'h01, 8'h00},  // R4 carry at bit 4
      {8'h00, 8'h08, 8'h00, 8'h1F, 8'hFF, 8'd16, 8'h03, 8'h00, 8'h01},  // R4 13-bit wrap
      {8'h20, 8'h10, 8'h01, 8'hFE, 8'hF0, 8'd16, 8'hF2, 8'hF0, 8'h01},  // R5 reload
      {8'h10, 8'h00, 8'h01, 8'h00, 8'h00, 8'd24, 8'h02, 8'h00, 8'h00},  // R2 timer 1 slow
      {8'h01, 8'h10, 8'h00, 8'h00, 8'h00, 8'd16, 8'h01, 8'h00, 8'h00}   // R2 rate bits independent
   };

   tmr_pair dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .t0_pin(t0_pin), .t1_pin(t1_pin),
      .gate0_in(gate0_in), .gate1_in(gate1_in), .ovf0_flag(ovf0_flag),
      .ovf1_flag(ovf1_flag), .baud_tick(baud_tick));

   always #(CLK_P / 2) clk = ~clk;

   always @(negedge clk) if (rst_n && baud_tick) baud_cnt = baud_cnt + 1;

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // called at a falling edge; the write lands on the next rising edge
   task automatic wr(input logic [2:0] sel, input logic [7:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] sel, output int v);
      rd_sel = sel;
      #1;
      v = int'(rd_data);
   endtask

   task automatic pulse0();
      t0_pin = 1'b0;
      repeat (4) @(negedge clk);
      t0_pin = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   initial begin : watchdog
      #(CLK_P * 100000);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int v, b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int s = 0; s < 7; s++) begin
         rd(3'(s), v);
         chk("R1 register", v, 0);
      end
      chk("R1 flags", {ovf1_flag, ovf0_flag, baud_tick}, 0);

      // table walk
      for (int i = 0; i < 7; i++) begin
         logic [71:0] e;
         logic [2:0]  sl;
         e  = VEC[i];
         sl = e[48] ? 3'd2 : 3'd0;
         @(negedge clk);
         wr(3'd5, 8'h00);
         wr(3'd4, e[71:64]);
         wr(3'd6, e[63:56]);
         wr(sl, e[47:40]);
         wr(sl + 3'd1, e[39:32]);
         wr(3'd5, e[48] ? 8'h02 : 8'h01);
         repeat (int'(e[31:24]) - 1) @(negedge clk);
         chk($sformatf("R3 R4 R5 flag vec%0d", i), e[48] ? ovf1_flag : ovf0_flag, int'(e[7:0]));
         wr(3'd5, 8'h00);
         rd(sl, v);
         chk($sformatf("R2 R3 R4 R5 low vec%0d", i), v, int'(e[23:16]));
         rd(sl + 3'd1, v);
         chk($sformatf("R2 R3 R4 R5 high vec%0d", i), v, int'(e[15:8]));
      end

      // R6 pin counting
      @(negedge clk);
      wr(3'd4, 8'h05);
      wr(3'd0, 8'h00);
      wr(3'd1, 8'h00);
      wr(3'd5, 8'h01);
      repeat (3) pulse0();
      repeat (10) @(negedge clk);
      wr(3'd5, 8'h00);
      rd(3'd0, v);
      chk("R6 pin edges", v, 3);

      // R7 gate
      wr(3'd4, 8'h09);
      wr(3'd6, 8'h08);
      wr(3'd0, 8'h00);
      gate0_in = 1'b0;
      wr(3'd5, 8'h01);
      repeat (15) @(negedge clk);
      wr(3'd5, 8'h00);
      rd(3'd0, v);
      chk("R7 gate low blocks", v, 0);
      gate0_in = 1'b1;
      wr(3'd5, 8'h01);
      repeat (7) @(negedge clk);
      wr(3'd5, 8'h00);
      rd(3'd0, v);
      chk("R7 gate high counts", v, 2);
      gate0_in = 1'b0;

      // R8 software-set flag stays until cleared
      wr(3'd5, 8'h04);
      repeat (6) @(negedge clk);
      chk("R8 flag held", ovf0_flag, 1);
      wr(3'd5, 8'h00);
      chk("R8 flag cleared", ovf0_flag, 0);

      // R9 write on a step edge wins
      wr(3'd4, 8'h01);
      wr(3'd0, 8'h00);
      wr(3'd1, 8'h00);
      wr(3'd5, 8'h01);
      repeat (3) @(negedge clk);
      wr(3'd0, 8'h50);
      wr(3'd5, 8'h00);
      rd(3'd0, v);
      chk("R9 write priority", v, 8'h50);

      // R10 split mode
      wr(3'd4, 8'h33);
      wr(3'd6, 8'h18);
      wr(3'd2, 8'h77);
      wr(3'd3, 8'h77);
      wr(3'd0, 8'hFE);
      wr(3'd1, 8'h10);
      wr(3'd5, 8'h03);
      repeat (11) @(negedge clk);
      chk("R10 low sets flag0", ovf0_flag, 1);
      chk("R10 no flag1 yet", ovf1_flag, 0);
      wr(3'd5, 8'h00);
      rd(3'd0, v);
      chk("R10 split low", v, 8'h01);
      rd(3'd1, v);
      chk("R10 split high", v, 8'h13);
      rd(3'd2, v);
      chk("R12 timer1 stopped in mode 3", v, 8'h77);
      wr(3'd1, 8'hFF);
      wr(3'd5, 8'h02);
      repeat (7) @(negedge clk);
      chk("R10 high sets flag1", ovf1_flag, 1);
      chk("R10 flag0 untouched", ovf0_flag, 0);
      wr(3'd5, 8'h00);
      rd(3'd1, v);
      chk("R10 high under run1", v, 8'h01);
      rd(3'd0, v);
      chk("R10 low idle without run0", v, 8'h01);

      // R11 timer 1 mode 3 holds when timer 0 is not split
      wr(3'd4, 8'h30);
      wr(3'd5, 8'h02);
      repeat (20) @(negedge clk);
      chk("R11 no flag1", ovf1_flag, 0);
      wr(3'd5, 8'h00);
      rd(3'd2, v);
      chk("R11 hold low", v, 8'h77);
      rd(3'd3, v);
      chk("R11 hold high", v, 8'h77);

      // R12 / R13 timer 1 run by its mode field while timer 0 is split
      wr(3'd4, 8'h33);
      wr(3'd2, 8'hFE);
      wr(3'd3, 8'hFF);
      b0 = baud_cnt;
      wr(3'd4, 8'h13);
      repeat (11) @(negedge clk);
      chk("R12 no flag1 from timer1", ovf1_flag, 0);
      wr(3'd4, 8'h33);
      rd(3'd2, v);
      chk("R12 timer1 low", v, 8'h01);
      rd(3'd3, v);
      chk("R12 timer1 high", v, 8'h00);
      repeat (10) @(negedge clk);
      rd(3'd2, v);
      chk("R12 timer1 stopped again", v, 8'h01);
      chk("R13 one baud pulse", baud_cnt - b0, 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule